// File: doc/BRIEF.md
# Second-Order Phase-Tracking Loop

This block follows a stream of fixed-point phase samples with a sampled phase-lock loop. Phase is held as an unsigned word whose full range stands for one turn, so every sum and difference wraps around the circle through plain binary overflow. For each accepted sample the loop forms the wrapped error between the sample and its own estimate. It adds a right-shifted copy of that error to a frequency register that carries extra fraction bits. It then moves the estimate forward by a second shifted copy of the error plus the integer part of the frequency register, much as a numerically controlled oscillator would.

The proportional shift (`alpha_sh`, gain 2^-a) and the integral shift (`beta_sh`, gain 2^-b) are sampled with each accepted phase word. The all-ones integral code switches the frequency path off, and the block then works as a first-order loop. A first-order loop removes a fixed phase offset but keeps a steady lag of about Δ·2^a when the input moves at Δ per sample. With the frequency path on, that lag is driven toward zero.

A small controller steps each update through four named states. `IDLE` waits with `in_ready` high. A valid sample moves it to `DETECT`, which registers the wrapped error. `INTEG` updates the frequency register. `ADVANCE` updates the phase estimate and raises `upd_done` for one cycle. The controller then returns to `IDLE`. Each of these transitions is unconditional except `IDLE`→`DETECT`, which needs `in_valid`.

Top module: `pll_track`

## Requirements
- R1: After reset `phase_est`, `phase_err` and `freq_est` are all zero and `in_ready` is 1.
- R2: The error registered for a sample equals (sample − estimate) mod 65536, read as a signed 16-bit value in [−32768, 32767]. A difference of exactly half a turn (0x8000) reads as −32768.
- R3: When `beta_sh` is not 15, `freq_est` (signed, 8 fraction bits) increases by (err·256) arithmetically shifted right by `beta_sh`.
- R4: `phase_est` becomes (estimate + (err >>> `alpha_sh`) + (new `freq_est` >>> 8)) mod 65536, using arithmetic shifts.
- R5: With `beta_sh` = 15, `freq_est` never changes. For a constant input with `alpha_sh` = 1 starting from reset, the error halves on every update (4096, 2048, 1024, ...).
- R6: First order (`alpha_sh` = 1, `beta_sh` = 15) on an input ramp of 64 per sample settles to a lag of 128 or 129. Second order (`alpha_sh` = 1, `beta_sh` = 4) on the same ramp settles to |err| ≤ 4, with `freq_est` >>> 8 between 63 and 65.
- R7: `in_valid` pulses while `in_ready` is 0 are ignored. They do not change any output, and no further update follows them.
- R8: The estimate and error wrap across 0xFFFF→0x0000 without a cycle slip. A ramp that runs through several turns keeps matching R2–R4 at every update.
- R9: `in_ready` drops the cycle after a sample is accepted. It returns high four cycles after acceptance, with `upd_done` high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Phase sample offered this cycle |
| in_phase | input | 16 | Input phase word, full range = one turn |
| alpha_sh | input | 4 | Proportional gain shift a (gain 2^-a) |
| beta_sh | input | 4 | Integral gain shift b. The value 15 disables the frequency path |
| in_ready | output | 1 | Block is idle and accepts a sample |
| upd_done | output | 1 | One-cycle pulse when an update completes |
| phase_est | output | 16 | Current phase estimate |
| phase_err | output | 16 | Last wrapped phase error, signed |
| freq_est | output | 24 | Frequency estimate, signed, 8 fraction bits |

## Verification
The hardest situation to reach is a settled loop whose estimate has wrapped around the circle several times. The only way to get there from the ports is hundreds of updates with a steadily moving input. The stimulus runs long ramps, first order and second order, and compares every update against an independent arithmetic model of the update equations. These runs cover the settled lag, zero-lag tracking and repeated wraparound. A short hand-computed table covers the half-turn error and the handover from first order to second order.

// File: rtl/pll_pkg.sv
package pll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DETECT  = 2'd1,
        ST_INTEG   = 2'd2,
        ST_ADVANCE = 2'd3
    } pll_state_e;

endpackage

// File: rtl/pll_phase_detect.sv
module pll_phase_detect #(
    parameter int PHASE_W = 16
) (
    input  logic [PHASE_W-1:0]        sample,
    input  logic [PHASE_W-1:0]        estimate,
    output logic signed [PHASE_W-1:0] err
);
    logic [PHASE_W-1:0] diff;

    // modular difference: overflow of the word is the wrap around the circle
    always_comb begin
        diff = sample - estimate;
        err  = signed'(diff);
    end
endmodule

// File: rtl/pll_loop_filter.sv
module pll_loop_filter #(
    parameter int PHASE_W = 16,
    parameter int FRAC_W  = 8,
    parameter int SHIFT_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              integ_en,
    input  logic signed [PHASE_W-1:0]         err,
    input  logic [SHIFT_W-1:0]                a_sh,
    input  logic [SHIFT_W-1:0]                b_sh,
    output logic signed [PHASE_W+FRAC_W-1:0]  freq,
    output logic signed [PHASE_W-1:0]         prop
);
    localparam int FREQ_W = PHASE_W + FRAC_W;
    localparam logic [SHIFT_W-1:0] OFF_CODE = {SHIFT_W{1'b1}};

    logic signed [FREQ_W-1:0] err_ext;
    logic signed [FREQ_W-1:0] integ_term;

    generate
        if (FRAC_W > 0) begin : g_frac
            assign err_ext = {err, {FRAC_W{1'b0}}};
        end else begin : g_nofrac
            assign err_ext = err;
        end
    endgenerate

    always_comb begin
        integ_term = err_ext >>> b_sh;
        prop       = err >>> a_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq <= '0;
        end else if (integ_en && (b_sh != OFF_CODE)) begin
            freq <= freq + integ_term;
        end
    end
endmodule

// File: rtl/pll_nco.sv
module pll_nco #(
    parameter int PHASE_W = 16,
    parameter int FRAC_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              adv_en,
    input  logic signed [PHASE_W-1:0]         prop,
    input  logic signed [PHASE_W+FRAC_W-1:0]  freq,
    output logic [PHASE_W-1:0]                theta
);
    localparam int FREQ_W = PHASE_W + FRAC_W;

    logic [PHASE_W-1:0] step;

    // integer part of the frequency word is its arithmetic shift by FRAC_W, truncated
    always_comb begin
        step = $unsigned(prop) + $unsigned(freq[FREQ_W-1:FRAC_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            theta <= '0;
        end else if (adv_en) begin
            theta <= theta + step;
        end
    end
endmodule

// File: rtl/pll_ctrl.sv
module pll_ctrl
    import pll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output pll_state_e state,
    output logic       ready,
    output logic       load,
    output logic       detect_en,
    output logic       integ_en,
    output logic       adv_en,
    output logic       done
);
    pll_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == ST_ADVANCE);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (in_valid) nxt = ST_DETECT;
            ST_DETECT:  nxt = ST_INTEG;
            ST_INTEG:   nxt = ST_ADVANCE;
            ST_ADVANCE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ready     = 1'b0;
        load      = 1'b0;
        detect_en = 1'b0;
        integ_en  = 1'b0;
        adv_en    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready = 1'b1;
                load  = in_valid;
            end
            ST_DETECT:  detect_en = 1'b1;
            ST_INTEG:   integ_en  = 1'b1;
            ST_ADVANCE: adv_en    = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pll_track.sv
module pll_track
    import pll_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int FRAC_W  = 8,
    parameter int SHIFT_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [PHASE_W-1:0]                 in_phase,
    input  logic [SHIFT_W-1:0]                 alpha_sh,
    input  logic [SHIFT_W-1:0]                 beta_sh,
    output logic                               in_ready,
    output logic                               upd_done,
    output logic [PHASE_W-1:0]                 phase_est,
    output logic signed [PHASE_W-1:0]          phase_err,
    output logic signed [PHASE_W+FRAC_W-1:0]   freq_est
);
    localparam int FREQ_W = PHASE_W + FRAC_W;

    pll_state_e st_cur;
    logic load, detect_en, integ_en, adv_en;
    logic [PHASE_W-1:0] sample_q;
    logic [SHIFT_W-1:0] alpha_q, beta_q;
    logic signed [PHASE_W-1:0] err_now;
    logic signed [PHASE_W-1:0] prop;
    logic signed [FREQ_W-1:0]  freq;
    logic [PHASE_W-1:0]        theta;

    pll_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .state     (st_cur),
        .ready     (in_ready),
        .load      (load),
        .detect_en (detect_en),
        .integ_en  (integ_en),
        .adv_en    (adv_en),
        .done      (upd_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q <= '0;
            alpha_q  <= '0;
            beta_q   <= '1;
        end else if (load) begin
            sample_q <= in_phase;
            alpha_q  <= alpha_sh;
            beta_q   <= beta_sh;
        end
    end

    pll_phase_detect #(.PHASE_W(PHASE_W)) u_det (
        .sample   (sample_q),
        .estimate (theta),
        .err      (err_now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_err <= '0;
        end else if (detect_en) begin
            phase_err <= err_now;
        end
    end

    pll_loop_filter #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .integ_en (integ_en),
        .err      (phase_err),
        .a_sh     (alpha_q),
        .b_sh     (beta_q),
        .freq     (freq),
        .prop     (prop)
    );

    pll_nco #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W)) u_nco (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_en (adv_en),
        .prop   (prop),
        .freq   (freq),
        .theta  (theta)
    );

    assign phase_est = theta;
    assign freq_est  = freq;
endmodule

// File: rtl/pll_track_chk.sv
module pll_track_chk
    import pll_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int FRAC_W  = 8,
    parameter int SHIFT_W = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        in_ready,
    input logic                        upd_done,
    input logic [PHASE_W-1:0]          phase_est,
    input logic [PHASE_W-1:0]          phase_err,
    input logic [PHASE_W+FRAC_W-1:0]   freq_est,
    input pll_state_e                  st_cur,
    input logic [SHIFT_W-1:0]          beta_q
);
    localparam logic [SHIFT_W-1:0] OFF_CODE = {SHIFT_W{1'b1}};

    p_freq_only_integ_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_est) |-> ($past(st_cur) == ST_INTEG));

    p_beta_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_est) |-> ($past(beta_q) != OFF_CODE));

    p_theta_only_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_est) |-> ($past(st_cur) == ST_ADVANCE));

    p_err_only_detect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_err) |-> ($past(st_cur) == ST_DETECT));

    p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> ($stable(phase_err) && $stable(phase_est) && $stable(freq_est)));

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> !in_ready);

    p_done_when_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> in_ready);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);
endmodule

bind pll_track pll_track_chk #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .upd_done  (upd_done),
    .phase_est (phase_est),
    .phase_err (phase_err),
    .freq_est  (freq_est),
    .st_cur    (st_cur),
    .beta_q    (beta_q)
);

// File: tb/test_pll_track.sv
module test_pll_track;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_phase = '0;
    logic [3:0]  alpha_sh = '0;
    logic [3:0]  beta_sh = 4'd15;
    logic        in_ready, upd_done;
    logic [15:0] phase_est;
    logic signed [15:0] phase_err;
    logic signed [23:0] freq_est;

    int checks = 0;
    int errors = 0;
    int m_theta = 0;
    int m_freq = 0;
    int m_err = 0;
    int last_wait = 0;

    always #4 clk = ~clk;

    pll_track i_pll_track (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
        .alpha_sh(alpha_sh), .beta_sh(beta_sh), .in_ready(in_ready), .upd_done(upd_done),
        .phase_est(phase_est), .phase_err(phase_err), .freq_est(freq_est)
    );

    // a, b, sample, expected err, expected freq, expected theta
    localparam int NVEC = 7;
    localparam int VEC [NVEC][6] = '{
        '{1, 15, 1000,   1000,   0,    500},
        '{1, 15, 1000,   500,    0,    750},
        '{1, 15, 1000,   250,    0,    875},
        '{1, 15, 33643, -32768,  0,    50027},
        '{1, 4,  50127,  100,    1600, 50083},
        '{1, 4,  50083,  0,      1600, 50089},
        '{1, 4,  50049, -40,     960,  50072}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_step(input int s, input int a, input int b);
        int e;
        e = (s - m_theta) & 16'hFFFF;
        if (e >= 32768) e -= 65536;
        m_err = e;
        if (b != 15) m_freq = m_freq + ((e * 256) >>> b);
        m_theta = (m_theta + (e >>> a) + (m_freq >>> 8)) & 16'hFFFF;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_theta = 0; m_freq = 0; m_err = 0;
        @(negedge clk);
    endtask

    task automatic do_update(input int s, input int a, input int b);
        int w;
        w = 0;
        while (!in_ready && w < 50) begin @(negedge clk); w++; end
        in_phase = s[15:0]; alpha_sh = a[3:0]; beta_sh = b[3:0];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        w = 1;
        while (!in_ready && w < 50) begin @(negedge clk); w++; end
        last_wait = w;
    endtask

    task automatic compare_model(input string tag);
        check(int'(phase_err) == m_err, {tag, " err"}, int'(phase_err), m_err);
        check(int'(freq_est) == m_freq, {tag, " freq"}, int'(freq_est), m_freq);
        check(int'(phase_est) == m_theta, {tag, " theta"}, int'(phase_est), m_theta);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1 reset state
        check(phase_est == 0, "R1 theta", int'(phase_est), 0);
        check(phase_err == 0, "R1 err", int'(phase_err), 0);
        check(freq_est == 0, "R1 freq", int'(freq_est), 0);
        check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);

        // vector table: R2 half-turn, R3 integral, R4 advance
        for (int i = 0; i < NVEC; i++) begin
            do_update(VEC[i][2], VEC[i][0], VEC[i][1]);
            check(int'(phase_err) == VEC[i][3], "R2 table err", int'(phase_err), VEC[i][3]);
            check(int'(freq_est) == VEC[i][4], "R3 table freq", int'(freq_est), VEC[i][4]);
            check(int'(phase_est) == VEC[i][5], "R4 table theta", int'(phase_est), VEC[i][5]);
        end

        // R9 latency and done pulse
        do_update(50072, 1, 4);
        check(last_wait == 4, "R9 latency", last_wait, 4);
        check(upd_done == 1'b1, "R9 done", int'(upd_done), 1);
        @(negedge clk);
        check(upd_done == 1'b0, "R9 done single", int'(upd_done), 0);

        // R5 first-order decay of a constant offset
        do_reset();
        for (int k = 0; k < 8; k++) begin
            do_update(4096, 1, 15);
            check(int'(phase_err) == (4096 >>> k), "R5 decay", int'(phase_err), 4096 >>> k);
            check(freq_est == 0, "R5 freq hold", int'(freq_est), 0);
        end

        // R7 pulses while busy are ignored
        do_reset();
        in_phase = 16'd3000; alpha_sh = 4'd2; beta_sh = 4'd3;
        in_valid = 1'b1;
        @(negedge clk);
        in_phase = 16'd40000; alpha_sh = 4'd0; beta_sh = 4'd0;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        model_step(3000, 2, 3);
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R7 no extra update", int'(in_ready), 1);
        compare_model("R7");

        // R6 first-order lag on a ramp
        do_reset();
        for (int k = 1; k <= 60; k++) begin
            do_update((64 * k) & 16'hFFFF, 1, 15);
            model_step((64 * k) & 16'hFFFF, 1, 15);
        end
        compare_model("R6 first");
        check(phase_err == 128 || phase_err == 129, "R6 lag", int'(phase_err), 128);

        // R6 second-order removes the lag
        do_reset();
        for (int k = 1; k <= 300; k++) begin
            do_update((64 * k) & 16'hFFFF, 1, 4);
            model_step((64 * k) & 16'hFFFF, 1, 4);
        end
        compare_model("R6 second");
        check(phase_err <= 4 && phase_err >= -4, "R6 zero lag", int'(phase_err), 0);
        check((freq_est >>> 8) >= 63 && (freq_est >>> 8) <= 65, "R6 freq", int'(freq_est >>> 8), 64);

        // R8 multi-turn ramp with wraparound, checked every update
        do_reset();
        for (int k = 1; k <= 400; k++) begin
            do_update((700 * k) & 16'hFFFF, 2, 6);
            model_step((700 * k) & 16'hFFFF, 2, 6);
            if (int'(phase_est) != m_theta || int'(phase_err) != m_err || int'(freq_est) != m_freq)
                compare_model("R8 wrap");
        end
        compare_model("R8 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule